// File: doc/BRIEF.md
# Split-Read SPI Register Bridge

This block is an SPI target that answers register reads one frame late. Each 32-bit frame is latched when chip select returns high. If the frame is a read, the block prepares a response. That response is shifted out on MISO during the following frame, whatever kind of frame it is. An all-ones frame is therefore a harmless way to collect a pending result.

Local reads are served from a small internal register file. Register 0 of that file gathers per-port completion events and clears them when it is read.

Remote reads go to one of several downstream ports. Each port has a request/done handshake toward an I2C master that sits outside this block. A port is busy from its request until its done pulse arrives. While a port is busy, collecting a result from it shows a BUSY flag. A second read that arrives at a port which is still busy is refused, and its response carries a REJECT flag.

Top module: `spi_split_read_bridge`

## Requirements
- R1: The response to a completed read frame is shifted out MSB first on MISO during the next frame, as a 32-bit word. Bits 31:16 of that word are zero, bit 15 is BUSY, bit 14 is REJECT and bits 7:0 are the data.
- R2: Frame layout, MSB first: bit 31 is 1 for a read and 0 for a write. Bits 30:24 select the target: 0 is local, and 1..NPORT is downstream port select-1. Bits 23:16 are the register address and bits 15:0 are write data, of which bits 7:0 are stored. A local write to register 1..NREG-1 stores the data.
- R3: An all-ones frame, or any read with an unused select, takes no action. During it, MISO still carries the previous frame's response. Its own response is all zeros.
- R4: Local register 0 reads back bit p set once port p has completed a read. Reading register 0 returns its value and then clears it. Writes to register 0 are ignored. A completion that lands in the same cycle as the clearing read is kept, so it shows in the next read.
- R5: A remote read to an idle port emits a one-cycle request on that port only, with the register address on the shared address output. The port stays busy until its done pulse.
- R6: When a remote read's response is collected while its port is still busy, the word shows BUSY=1 and data 0. When the port is idle at collection, BUSY is 0 and the data is the port's latest result.
- R7: A remote read to a busy port issues no request. Its response shows REJECT=1.
- R8: Responses to local reads have BUSY=0 and REJECT=0.
- R9: A frame in which chip select rises before 32 clock edges is discarded. It causes no write, no request and no change to the pending response.
- R10: After reset the pending response is zero, no port is busy, all registers are zero and no request is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from controller |
| spi_miso | output | 1 | SPI data to controller |
| dn_req | output | NPORT | One-cycle read request, one bit per downstream port |
| dn_reg | output | 8 | Register address of the latest request |
| dn_done | input | NPORT | One-cycle completion pulse per port |
| dn_rdata | input | NPORT*8 | Completion data, 8 bits per port, port 0 lowest |

## Verification
Two functions can land in the same cycle: a downstream completion setting its event bit in register 0, and a committed read of register 0 clearing that register. The bench provokes this by holding port 0's completion under manual control. It then releases the completion at a sweep of offsets around the moment the register 0 read commits. At each offset the event must appear in exactly one of two back-to-back reads of register 0: never lost, never reported twice.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    localparam int FRAME_W  = 32;
    localparam int SEL_W    = 7;
    localparam int ADDR_W   = 8;
    localparam int WDATA_W  = 16;
    localparam int DATA_W   = 8;
    localparam int BUSY_BIT = 15;
    localparam int REJ_BIT  = 14;

    localparam logic [SEL_W-1:0] SEL_LOCAL = '0;

    typedef struct packed {
        logic               rd;
        logic [SEL_W-1:0]   sel;
        logic [ADDR_W-1:0]  addr;
        logic [WDATA_W-1:0] wdata;
    } frame_t;

    typedef enum logic [1:0] {
        STG_NONE   = 2'd0,
        STG_LOCAL  = 2'd1,
        STG_REMOTE = 2'd2
    } stg_kind_e;

    typedef struct packed {
        stg_kind_e         kind;
        logic [SEL_W-1:0]  port;
        logic              reject;
        logic [DATA_W-1:0] ldata;
    } stage_t;

    typedef enum logic [1:0] {
        OP_NONE        = 2'd0,
        OP_WRITE_LOCAL = 2'd1,
        OP_READ_LOCAL  = 2'd2,
        OP_READ_REMOTE = 2'd3
    } op_e;

    function automatic logic [FRAME_W-1:0] make_resp(
        input logic              busy,
        input logic              reject,
        input logic [DATA_W-1:0] data
    );
        logic [FRAME_W-1:0] w;
        w              = '0;
        w[BUSY_BIT]    = busy;
        w[REJ_BIT]     = reject;
        w[DATA_W-1:0]  = data;
        return w;
    endfunction

    function automatic op_e classify(input frame_t f, input int nport, input int nreg);
        if (f.sel == SEL_LOCAL) begin
            if (int'(f.addr) >= nreg) return OP_NONE;
            return f.rd ? OP_READ_LOCAL : OP_WRITE_LOCAL;
        end
        if (f.rd && int'(f.sel) >= 1 && int'(f.sel) <= nport) return OP_READ_REMOTE;
        return OP_NONE;
    endfunction

endpackage

// File: rtl/sbr_spi_shifter.sv
module sbr_spi_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sclk,
    input  logic         cs_n,
    input  logic         mosi,
    input  logic [W-1:0] tx_word,
    output logic         miso,
    output logic         frame_done,
    output logic [W-1:0] frame_word
);
    localparam int CNT_W = $clog2(W) + 1;

    logic [2:0]       sclk_q;
    logic [2:0]       cs_q;
    logic [1:0]       mosi_q;
    logic [W-1:0]     tx_sh;
    logic [W-1:0]     rx_sh;
    logic [W-1:0]     rx_q;
    logic [CNT_W-1:0] cnt;
    logic             done_q;

    logic sclk_rise, sclk_fall, cs_fall, cs_rise, in_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= {sclk_q[1:0], sclk};
            cs_q   <= {cs_q[1:0], cs_n};
            mosi_q <= {mosi_q[0], mosi};
        end
    end

    assign sclk_rise = sclk_q[1] & ~sclk_q[2];
    assign sclk_fall = ~sclk_q[1] & sclk_q[2];
    assign cs_fall   = ~cs_q[1] & cs_q[2];
    assign cs_rise   = cs_q[1] & ~cs_q[2];
    assign in_frame  = ~cs_q[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh  <= '0;
            rx_sh  <= '0;
            rx_q   <= '0;
            cnt    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (cs_fall) begin
                tx_sh <= tx_word;
                rx_sh <= '0;
                cnt   <= '0;
            end else if (cs_rise) begin
                done_q <= (cnt == CNT_W'(W));
                rx_q   <= rx_sh;
            end else if (in_frame) begin
                if (sclk_rise) begin
                    rx_sh <= {rx_sh[W-2:0], mosi_q[1]};
                    if (cnt != '1) cnt <= cnt + 1'b1;
                end
                if (sclk_fall) tx_sh <= {tx_sh[W-2:0], 1'b0};
            end
        end
    end

    assign miso       = tx_sh[W-1];
    assign frame_done = done_q;
    assign frame_word = rx_q;

endmodule

// File: rtl/sbr_local_regs.sv
module sbr_local_regs
    import sbr_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int NPORT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_clr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NPORT-1:0]  evt,
    output logic [DATA_W-1:0] rd_data,
    output logic [NPORT-1:0]  ev_bits
);
    logic [NPORT-1:0]  ev_q;
    logic [DATA_W-1:0] view [NREG];

    // Register 0: completion events, cleared by a committed read; a
    // completion in the clearing cycle is OR-ed back in so it is not lost.
    always_ff @(posedge clk) begin
        if (rst) ev_q <= '0;
        else     ev_q <= ((rd_clr && addr == '0) ? '0 : ev_q) | evt;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == 0) begin : g_evt
            assign view[g] = DATA_W'(ev_q);
        end else begin : g_plain
            logic [DATA_W-1:0] r_q;
            always_ff @(posedge clk) begin
                if (rst)                                r_q <= '0;
                else if (wr_en && addr == ADDR_W'(g))   r_q <= wr_data;
            end
            assign view[g] = r_q;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (addr == ADDR_W'(i)) rd_data = view[i];
        end
    end

    assign ev_bits = ev_q;

endmodule

// File: rtl/sbr_port_slot.sv
module sbr_port_slot
    import sbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic              done,
    input  logic [DATA_W-1:0] data,
    output logic              busy,
    output logic [DATA_W-1:0] result,
    output logic              evt
);
    logic              busy_q;
    logic [DATA_W-1:0] res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            res_q  <= '0;
        end else if (busy_q && done) begin
            busy_q <= 1'b0;
            res_q  <= data;
        end else if (issue) begin
            busy_q <= 1'b1;
        end
    end

    assign busy   = busy_q;
    assign result = res_q;
    assign evt    = busy_q & done;

endmodule

// File: rtl/spi_split_read_bridge.sv
module spi_split_read_bridge
    import sbr_pkg::*;
#(
    parameter int NPORT = 2,
    parameter int NREG  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    spi_sclk,
    input  logic                    spi_cs_n,
    input  logic                    spi_mosi,
    output logic                    spi_miso,
    output logic [NPORT-1:0]        dn_req,
    output logic [ADDR_W-1:0]       dn_reg,
    input  logic [NPORT-1:0]        dn_done,
    input  logic [NPORT*DATA_W-1:0] dn_rdata
);
    logic [FRAME_W-1:0] tx_word;
    logic [FRAME_W-1:0] frame_word;
    logic               frame_done;
    frame_t             fr;
    op_e                op;

    logic [NPORT-1:0]  port_busy;
    logic [NPORT-1:0]  port_evt;
    logic [DATA_W-1:0] port_res [NPORT];
    logic [NPORT-1:0]  ev_bits;
    logic [DATA_W-1:0] rd_data;

    logic [NPORT-1:0]  tgt_hot;
    logic              tgt_busy;
    logic              issue;
    logic [NPORT-1:0]  req_q;
    logic [ADDR_W-1:0] reg_q;
    stage_t            stage_q;

    sbr_spi_shifter #(.W(FRAME_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .sclk       (spi_sclk),
        .cs_n       (spi_cs_n),
        .mosi       (spi_mosi),
        .tx_word    (tx_word),
        .miso       (spi_miso),
        .frame_done (frame_done),
        .frame_word (frame_word)
    );

    assign fr = frame_t'(frame_word);
    assign op = classify(fr, NPORT, NREG);

    always_comb begin
        tgt_hot  = '0;
        tgt_busy = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            if (int'(fr.sel) == p + 1) begin
                tgt_hot[p] = 1'b1;
                tgt_busy   = port_busy[p];
            end
        end
    end

    assign issue = frame_done && (op == OP_READ_REMOTE) && !tgt_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            reg_q <= '0;
        end else begin
            req_q <= issue ? tgt_hot : '0;
            if (issue) reg_q <= fr.addr;
        end
    end

    assign dn_req = req_q;
    assign dn_reg = reg_q;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        sbr_port_slot u_slot (
            .clk    (clk),
            .rst    (rst),
            .issue  (req_q[p]),
            .done   (dn_done[p]),
            .data   (dn_rdata[p*DATA_W +: DATA_W]),
            .busy   (port_busy[p]),
            .result (port_res[p]),
            .evt    (port_evt[p])
        );
    end

    sbr_local_regs #(.NREG(NREG), .NPORT(NPORT)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (frame_done && op == OP_WRITE_LOCAL),
        .rd_clr  (frame_done && op == OP_READ_LOCAL),
        .addr    (fr.addr),
        .wr_data (fr.wdata[DATA_W-1:0]),
        .evt     (port_evt),
        .rd_data (rd_data),
        .ev_bits (ev_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '{kind: STG_NONE, port: '0, reject: 1'b0, ldata: '0};
        end else if (frame_done) begin
            case (op)
                OP_READ_LOCAL:
                    stage_q <= '{kind: STG_LOCAL, port: '0, reject: 1'b0, ldata: rd_data};
                OP_READ_REMOTE:
                    stage_q <= '{kind: STG_REMOTE, port: fr.sel - 1'b1, reject: tgt_busy, ldata: '0};
                default:
                    stage_q <= '{kind: STG_NONE, port: '0, reject: 1'b0, ldata: '0};
            endcase
        end
    end

    // Response word sampled by the shifter when chip select falls; remote
    // status is read live so a poll reflects the port at collection time.
    always_comb begin
        logic              b;
        logic [DATA_W-1:0] r;
        b = 1'b0;
        r = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (int'(stage_q.port) == p) begin
                b = port_busy[p];
                r = port_res[p];
            end
        end
        case (stage_q.kind)
            STG_LOCAL:  tx_word = make_resp(1'b0, 1'b0, stage_q.ldata);
            STG_REMOTE: tx_word = make_resp(b, stage_q.reject, b ? '0 : r);
            default:    tx_word = '0;
        endcase
    end

endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
    parameter int NPORT = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [NPORT-1:0] dn_req,
    input logic [NPORT-1:0] dn_done,
    input logic [NPORT-1:0] port_busy,
    input logic [NPORT-1:0] ev_bits,
    input logic             frame_done
);
    a_r5_req_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dn_req));

    a_r5_req_marks_busy: assert property (@(posedge clk) disable iff (rst)
        (|dn_req) |=> ((port_busy & $past(dn_req)) == $past(dn_req)));

    a_r7_no_req_to_busy: assert property (@(posedge clk) disable iff (rst)
        (|dn_req) |-> ((dn_req & $past(port_busy)) == '0));

    a_r6_done_frees_port: assert property (@(posedge clk) disable iff (rst)
        (|(port_busy & dn_done)) |=> ((port_busy & $past(port_busy & dn_done)) == '0));

    a_r4_done_sets_event: assert property (@(posedge clk) disable iff (rst)
        (|(port_busy & dn_done)) |=>
            ((ev_bits & $past(port_busy & dn_done)) == $past(port_busy & dn_done)));

    a_r9_req_needs_frame: assert property (@(posedge clk) disable iff (rst)
        (|dn_req) |-> $past(frame_done));

endmodule

bind spi_split_read_bridge sbr_checker #(.NPORT(NPORT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dn_req     (dn_req),
    .dn_done    (dn_done),
    .port_busy  (port_busy),
    .ev_bits    (ev_bits),
    .frame_done (frame_done)
);

// File: tb/spi_split_read_bridge_tb.sv
module spi_split_read_bridge_tb;
    localparam int NPORT = 2;
    localparam int NREG  = 8;
    localparam logic [31:0] DUMMY = 32'hFFFF_FFFF;
    localparam logic [31:0] FULL  = 32'hFFFF_FFFF;
    localparam logic [31:0] NOB0  = 32'hFFFF_FFFE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;
    logic [NPORT-1:0]   dn_req;
    logic [7:0]         dn_reg;
    logic [NPORT-1:0]   dn_done;
    logic [NPORT*8-1:0] dn_rdata;

    int tests = 0;
    int fails = 0;
    bit manual0 = 1'b0;
    int fire0 = 0;
    logic [31:0] last_rx = '0;

    logic [31:0] exp_q [$];
    logic [31:0] mask_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    spi_split_read_bridge #(.NPORT(NPORT), .NREG(NREG)) u_dut (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .dn_req(dn_req), .dn_reg(dn_reg), .dn_done(dn_done),
        .dn_rdata(dn_rdata)
    );

    function automatic logic [7:0] dn_val(input int p, input logic [7:0] a);
        return a ^ (8'hA5 + 8'(p));
    endfunction

    function automatic logic [31:0] fw(input bit rd, input int sel, input int addr, input int wd);
        return {rd, 7'(sel), 8'(addr), 16'(wd)};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Downstream models: port 0 at the 400 kHz latency (170), port 1 at the
    // 100 kHz latency (620); one modelled microsecond is one clock cycle.
    for (genvar g = 0; g < NPORT; g++) begin : g_dn
        localparam int LAT = (g == 0) ? 170 : 620;
        logic       done_r = 1'b0;
        logic [7:0] data_r = '0;
        int         req_cnt = 0;
        logic [7:0] last_addr = '0;
        assign dn_done[g] = done_r;
        assign dn_rdata[g*8 +: 8] = data_r;
        initial begin
            int seen;
            logic [7:0] a;
            forever begin
                @(posedge clk);
                if (dn_req[g]) begin
                    a = dn_reg;
                    req_cnt++;
                    last_addr = a;
                    if (g == 0 && manual0) begin
                        seen = fire0;
                        wait (fire0 != seen);
                    end else begin
                        repeat (LAT) @(posedge clk);
                    end
                    @(negedge clk);
                    done_r = 1'b1;
                    data_r = dn_val(g, a);
                    @(negedge clk);
                    done_r = 1'b0;
                end
            end
        end
    end

    // Monitor: collects each MISO word and scores it against the queue.
    initial begin
        logic [31:0] sh;
        logic [31:0] e, m;
        string t;
        int n;
        forever begin
            @(negedge cs_n);
            n = 0;
            sh = '0;
            while (1) begin
                @(posedge sclk or posedge cs_n);
                if (cs_n) break;
                sh = {sh[30:0], miso};
                n++;
            end
            if (n == 32) begin
                last_rx = sh;
                if (exp_q.size() == 0) begin
                    check(1'b0, "scoreboard empty", sh, '0);
                end else begin
                    e = exp_q.pop_front();
                    m = mask_q.pop_front();
                    t = tag_q.pop_front();
                    check((sh & m) == (e & m), t, sh, e);
                end
            end
        end
    end

    task automatic frame(input logic [31:0] w, input int nbits, input logic [31:0] exp,
                         input logic [31:0] mask, input string tag, input int fire_k);
        if (nbits == 32) begin
            exp_q.push_back(exp);
            mask_q.push_back(mask);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = w[31-i];
            repeat (8) @(negedge clk);
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        if (fire_k >= 0) begin
            repeat (fire_k) @(negedge clk);
            fire0++;
        end
        repeat (16) @(negedge clk);
    endtask

    task automatic fx(input logic [31:0] w, input logic [31:0] exp, input string tag);
        frame(w, 32, exp, FULL, tag, -1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic a_bit, b_bit;
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(miso == 1'b0 && dn_req == '0, "R10 reset outputs", {30'b0, miso, |dn_req}, '0);
        fx(DUMMY, 32'h0, "R10 reset response");

        // local write and read path
        fx(fw(0, 0, 1, 16'h003C), 32'h0, "R2 write reg1");
        fx(fw(0, 0, 2, 16'h00C3), 32'h0, "R2 write reg2");
        fx(fw(1, 0, 1, 0), 32'h0, "R1 prior none");
        fx(fw(1, 0, 2, 0), 32'h3C, "R1 R2 R8 reg1 data");
        fx(DUMMY, 32'hC3, "R3 dummy carries reg2");
        fx(DUMMY, 32'h0, "R3 dummy own response");

        // register 0 ignores writes
        fx(fw(0, 0, 0, 16'h00FF), 32'h0, "R4 write reg0");
        fx(fw(1, 0, 0, 0), 32'h0, "R4 read reg0");
        fx(DUMMY, 32'h0, "R4 reg0 write ignored");

        // aborted frames
        frame(fw(0, 0, 1, 16'h0011), 20, 0, FULL, "", -1);
        fx(fw(1, 0, 1, 0), 32'h0, "R9 prior");
        fx(DUMMY, 32'h3C, "R9 aborted write dropped");
        fx(fw(1, 0, 1, 0), 32'h0, "R9 prior2");
        frame(fw(1, 0, 2, 0), 16, 0, FULL, "", -1);
        fx(DUMMY, 32'h3C, "R9 aborted read kept stage");
        frame(fw(1, 1, 8'h30, 0), 24, 0, FULL, "", -1);
        repeat (300) @(negedge clk);
        check(g_dn[0].req_cnt == 0, "R9 aborted remote no request", g_dn[0].req_cnt, 0);

        // unused select
        fx(fw(1, 5, 3, 0), 32'h0, "R3 prior");
        fx(DUMMY, 32'h0, "R3 unused select zero");
        check(g_dn[0].req_cnt + g_dn[1].req_cnt == 0, "R3 unused select no request",
              g_dn[0].req_cnt + g_dn[1].req_cnt, 0);

        // remote read, early poll then late poll
        fx(fw(1, 1, 8'h21, 0), 32'h0, "R6 prior");
        fx(DUMMY, 32'h8000, "R6 early poll busy");
        check(g_dn[0].req_cnt == 1, "R5 one request", g_dn[0].req_cnt, 1);
        check(g_dn[0].last_addr == 8'h21, "R5 request address", g_dn[0].last_addr, 8'h21);
        fx(fw(1, 1, 8'h22, 0), 32'h0, "R5 prior");
        repeat (400) @(negedge clk);
        fx(DUMMY, {24'h0, dn_val(0, 8'h22)}, "R6 late poll data");

        // events and self-clear
        fx(fw(1, 0, 0, 0), 32'h0, "R4 prior");
        fx(fw(1, 0, 0, 0), 32'h01, "R4 port0 event");
        fx(DUMMY, 32'h0, "R4 self-clear on repeat");

        // reject on busy port
        fx(fw(1, 2, 8'h40, 0), 32'h0, "R7 prior");
        fx(fw(1, 2, 8'h41, 0), 32'h8000, "R6 port1 busy");
        repeat (800) @(negedge clk);
        fx(DUMMY, 32'h4000 | {24'h0, dn_val(1, 8'h40)}, "R7 reject flag");
        check(g_dn[1].req_cnt == 1, "R7 rejected read not issued", g_dn[1].req_cnt, 1);
        check(g_dn[1].last_addr == 8'h40, "R7 address of first read", g_dn[1].last_addr, 8'h40);
        fx(fw(1, 0, 0, 0), 32'h0, "R4 prior2");
        fx(DUMMY, 32'h02, "R4 port1 event");

        // same-cycle completion and clearing read
        manual0 = 1'b1;
        for (int k = 0; k < 9; k++) begin
            fx(fw(1, 1, 8'h50 + k, 0), 32'h0, "R4 sweep prior");
            frame(fw(1, 0, 0, 0), 32, 32'h8000, FULL, "R6 sweep busy", k);
            frame(fw(1, 0, 0, 0), 32, 32'h0, NOB0, "R4 sweep first read", -1);
            a_bit = last_rx[0];
            frame(DUMMY, 32, 32'h0, NOB0, "R4 sweep second read", -1);
            b_bit = last_rx[0];
            check((a_bit ^ b_bit) == 1'b1, "R4 race event exactly once",
                  {30'b0, a_bit, b_bit}, 32'h1);
        end
        manual0 = 1'b0;

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule